// File: doc/BRIEF.md
# Peripheral Quadrant Write Guard

This block keeps one protection flag for every quadrant of peripheral selects 8 through 23. It uses those flags to decide whether an access to a quadrant may go ahead. Each select has four quadrants, so one 32-bit word holds the flags for eight selects. Two such words cover the sixteen governed selects.

Software reaches each word through two aliases on a plain register bus that carries a privilege flag:

- Writing ones to the set alias raises flags.
- Writing ones to the clear alias drops flags.
- Both aliases read back the same stored word.

Only privileged writes change anything. A parameter mask marks which bit positions have a peripheral behind them. The positions it leaves out never hold a 1.

A separate check port sits beside the bus. It takes a select, a quadrant, a read/write flag and a privilege flag, and it answers allow or deny. The answer is combinational from the stored flags.

Top module: `periph_quad_guard`

## Requirements
- R1: After reset every protection flag is 0, so both words read 0x00000000 through every alias.
- R2: The flag for select s (8..23) and quadrant q (0..3) is bit (s-8)*4+q of a flat 64-bit vector. Bits 31:0 form the word for selects 8..15, and bits 63:32 form the word for selects 16..23.
- R3: A privileged write of 1 to a bit of a set alias (offset 0x24 for selects 8..15, 0x28 for selects 16..23) sets that flag. A 0 bit leaves its flag unchanged.
- R4: A privileged write of 1 to a bit of a clear alias (offset 0x44 for selects 8..15, 0x48 for selects 16..23) clears that flag, and a 0 bit leaves it unchanged. A read of a clear alias returns the same value as the matching set alias.
- R5: A write with the privilege flag low to any alias changes no flag.
- R6: A bit position whose implemented-mask bit is 0 ignores writes and always reads 0. Its quadrant therefore checks as unprotected.
- R7: A read access on the check port is always allowed, and so is a privileged write access.
- R8: A user write access is denied exactly when its quadrant's flag is 1. Selects outside 8..23 are always allowed.
- R9: A read at an offset other than the four aliases returns 0, and a write there changes no flag.
- R10: The check output follows the stored flags combinationally. A flag write captured on a clock edge changes the answer from that edge on, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe, captured on the rising clock edge |
| bus_priv | input | 1 | Privilege flag of the register write |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| chk_sel | input | 5 | Peripheral select of the access being checked |
| chk_quad | input | 2 | Quadrant of the access being checked |
| chk_write | input | 1 | 1 for a write access, 0 for a read access |
| chk_priv | input | 1 | Privilege flag of the access being checked |
| chk_allow | output | 1 | 1 when the checked access may proceed |

## Verification
The bench builds the block with an implemented mask of 0x0FFFFFFF_FFFFFF0F. This leaves quadrants 0..3 of select 9 and of select 23 without a peripheral. The gaps let the bench write all-ones patterns and see masked positions stay 0 on readback. They also let it see those quadrants admit user writes. The default all-ones mask can show neither effect.

// File: rtl/pqg_pkg.sv
package pqg_pkg;
  localparam int QUADS        = 4;
  localparam int QUAD_W       = 2;
  localparam int WORD_W       = 32;
  localparam int SELS_PER_WORD = WORD_W / QUADS;
endpackage

// File: rtl/pqg_decode.sv
module pqg_decode #(
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 2,
  parameter int SET_BASE = 'h24,
  parameter int CLR_BASE = 'h44
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_REGS-1:0] set_hit,
  output logic [NUM_REGS-1:0] clr_hit,
  output logic [NUM_REGS-1:0] rd_hit
);
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_hit
    localparam logic [ADDR_W-1:0] SET_OFF = ADDR_W'(SET_BASE + 4 * k);
    localparam logic [ADDR_W-1:0] CLR_OFF = ADDR_W'(CLR_BASE + 4 * k);
    assign set_hit[k] = (addr == SET_OFF);
    assign clr_hit[k] = (addr == CLR_OFF);
    assign rd_hit[k]  = set_hit[k] | clr_hit[k];
  end
endmodule

// File: rtl/pqg_prot_word.sv
module pqg_prot_word #(
  parameter int          WIDTH = 32,
  parameter logic [31:0] MASK  = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ok,
  input  logic             set_hit,
  input  logic             clr_hit,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] eff;
  assign eff = wdata & MASK[WIDTH-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                q <= '0;
    else if (wr_ok && set_hit) q <= q | eff;
    else if (wr_ok && clr_hit) q <= q & ~eff;
  end
endmodule

// File: rtl/pqg_access_gate.sv
module pqg_access_gate #(
  parameter int NUM_BITS  = 64,
  parameter int SEL_W     = 5,
  parameter int FIRST_SEL = 8,
  parameter int NUM_SEL   = 16
) (
  input  logic [NUM_BITS-1:0] prot,
  input  logic [SEL_W-1:0]    sel,
  input  logic [1:0]          quad,
  input  logic                write,
  input  logic                priv,
  output logic                allow
);
  localparam logic [SEL_W-1:0] LO = SEL_W'(FIRST_SEL);
  localparam logic [SEL_W:0]   HI = (SEL_W + 1)'(FIRST_SEL + NUM_SEL);

  logic             in_range;
  logic [SEL_W-1:0] off;
  logic [SEL_W+1:0] idx;
  logic             flag;

  assign in_range = (sel >= LO) && ({1'b0, sel} < HI);
  assign off      = sel - LO;
  assign idx      = {off, quad};
  assign flag     = in_range && |(prot & (NUM_BITS'(1) << idx));
  assign allow    = !write || priv || !flag;
endmodule

// File: rtl/periph_quad_guard.sv
module periph_quad_guard #(
  parameter int ADDR_W    = 8,
  parameter int SEL_W     = 5,
  parameter int NUM_REGS  = 2,
  parameter int FIRST_SEL = 8,
  parameter int SET_BASE  = 'h24,
  parameter int CLR_BASE  = 'h44,
  parameter logic [NUM_REGS*32-1:0] IMPL_MASK = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_priv,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [SEL_W-1:0]  chk_sel,
  input  logic [1:0]        chk_quad,
  input  logic              chk_write,
  input  logic              chk_priv,
  output logic              chk_allow
);
  import pqg_pkg::*;

  localparam int NUM_BITS = NUM_REGS * WORD_W;
  localparam int NUM_SEL  = NUM_REGS * SELS_PER_WORD;

  logic [NUM_REGS-1:0] set_hit, clr_hit, rd_hit;
  logic [NUM_BITS-1:0] prot_flat;
  logic                wr_ok;

  assign wr_ok = bus_wr && bus_priv;

  pqg_decode #(
    .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS),
    .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)
  ) u_dec (
    .addr(bus_addr), .set_hit(set_hit), .clr_hit(clr_hit), .rd_hit(rd_hit)
  );

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_word
    pqg_prot_word #(
      .WIDTH(WORD_W), .MASK(IMPL_MASK[k*WORD_W +: WORD_W])
    ) u_word (
      .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok),
      .set_hit(set_hit[k]), .clr_hit(clr_hit[k]),
      .wdata(bus_wdata), .q(prot_flat[k*WORD_W +: WORD_W])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int k = 0; k < NUM_REGS; k++)
      if (rd_hit[k]) bus_rdata = bus_rdata | prot_flat[k*WORD_W +: WORD_W];
  end

  pqg_access_gate #(
    .NUM_BITS(NUM_BITS), .SEL_W(SEL_W),
    .FIRST_SEL(FIRST_SEL), .NUM_SEL(NUM_SEL)
  ) u_gate (
    .prot(prot_flat), .sel(chk_sel), .quad(chk_quad),
    .write(chk_write), .priv(chk_priv), .allow(chk_allow)
  );
endmodule

// File: rtl/pqg_sva.sv
module pqg_sva #(
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 2,
  parameter int SET_BASE = 'h24,
  parameter int CLR_BASE = 'h44,
  parameter logic [NUM_REGS*32-1:0] IMPL_MASK = '1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_wr,
  input logic                   bus_priv,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic [31:0]            bus_wdata,
  input logic                   chk_write,
  input logic                   chk_priv,
  input logic                   chk_allow,
  input logic [NUM_REGS*32-1:0] prot_flat
);
  p_user_wr_discard_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_priv) |=> $stable(prot_flat));

  p_unimpl_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_flat & ~IMPL_MASK) == '0);

  p_read_allowed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_write |-> chk_allow);

  p_priv_allowed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    chk_priv |-> chk_allow);

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_chk
    localparam logic [ADDR_W-1:0] SOFF = ADDR_W'(SET_BASE + 4 * k);
    localparam logic [ADDR_W-1:0] COFF = ADDR_W'(CLR_BASE + 4 * k);
    localparam logic [31:0]       M    = IMPL_MASK[k*32 +: 32];

    p_set_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_priv && bus_addr == SOFF) |=>
      prot_flat[k*32 +: 32] == ($past(prot_flat[k*32 +: 32]) | ($past(bus_wdata) & M)));

    p_clr_alias_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_priv && bus_addr == COFF) |=>
      prot_flat[k*32 +: 32] == ($past(prot_flat[k*32 +: 32]) & ~($past(bus_wdata) & M)));
  end
endmodule

bind periph_quad_guard pqg_sva #(
  .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .SET_BASE(SET_BASE),
  .CLR_BASE(CLR_BASE), .IMPL_MASK(IMPL_MASK)
) u_sva (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_priv(bus_priv),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .chk_write(chk_write),
  .chk_priv(chk_priv), .chk_allow(chk_allow), .prot_flat(prot_flat)
);

// File: tb/tb_periph_quad_guard.sv
module tb_periph_quad_guard;
  localparam logic [63:0] MASK = 64'h0FFF_FFFF_FFFF_FF0F;
  localparam int NV = 14;
  // {is_read, priv, addr, data}; for reads, data is the expected value
  localparam logic [41:0] VEC [NV] = '{
    {1'b0, 1'b1, 8'h24, 32'hFFFF_FFFF},
    {1'b1, 1'b0, 8'h24, 32'hFFFF_FF0F},
    {1'b1, 1'b0, 8'h44, 32'hFFFF_FF0F},
    {1'b0, 1'b0, 8'h44, 32'hFFFF_FFFF},
    {1'b1, 1'b0, 8'h24, 32'hFFFF_FF0F},
    {1'b0, 1'b1, 8'h44, 32'h0000_FF00},
    {1'b1, 1'b1, 8'h44, 32'hFFFF_000F},
    {1'b0, 1'b1, 8'h24, 32'h0000_0000},
    {1'b1, 1'b0, 8'h24, 32'hFFFF_000F},
    {1'b0, 1'b1, 8'h28, 32'hF000_0001},
    {1'b1, 1'b0, 8'h48, 32'h0000_0001},
    {1'b0, 1'b0, 8'h28, 32'h0000_FFFF},
    {1'b1, 1'b0, 8'h28, 32'h0000_0001},
    {1'b1, 1'b0, 8'h30, 32'h0000_0000}
  };
  localparam string VREQ [NV] = '{"R3", "R6", "R4", "R5", "R5", "R4", "R4",
                                  "R3", "R3", "R6", "R4", "R5", "R2", "R9"};

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_priv = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [4:0] chk_sel = 0;
  logic [1:0] chk_quad = 0;
  logic chk_write = 0, chk_priv = 0, chk_allow;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  periph_quad_guard #(.IMPL_MASK(MASK)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_priv(bus_priv),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .chk_sel(chk_sel), .chk_quad(chk_quad), .chk_write(chk_write),
    .chk_priv(chk_priv), .chk_allow(chk_allow)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic priv, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_priv = priv; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_priv = 0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1 check(req, bus_rdata, exp);
  endtask

  task automatic acc(input string req, input int sel, input int q, input logic w,
                     input logic p, input logic exp);
    @(negedge clk);
    chk_sel = 5'(sel); chk_quad = 2'(q); chk_write = w; chk_priv = p;
    #1 check(req, {31'b0, chk_allow}, {31'b0, exp});
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd("R1", 8'h24, 0); rd("R1", 8'h48, 0);
    acc("R1", 8, 0, 1, 0, 1);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][41]) rd(VREQ[i], VEC[i][39:32], VEC[i][31:0]);
      else            wr(VEC[i][40], VEC[i][39:32], VEC[i][31:0]);
    end
    // word0 = FFFF000F, word1 = 00000001
    acc("R8", 8, 0, 1, 0, 0);
    acc("R7", 8, 0, 0, 0, 1);
    acc("R7", 8, 0, 1, 1, 1);
    acc("R8", 10, 0, 1, 0, 1);
    acc("R6", 9, 0, 1, 0, 1);
    acc("R2", 15, 3, 1, 0, 0);
    acc("R2", 16, 0, 1, 0, 0);
    acc("R2", 16, 1, 1, 0, 1);
    acc("R8", 5, 0, 1, 0, 1);
    acc("R8", 24, 0, 1, 0, 1);
    wr(1, 8'h30, 32'hFFFF_FFFF);
    rd("R9", 8'h24, 32'hFFFF_000F);
    rd("R9", 8'h28, 32'h0000_0001);

    // R10: select 17 quadrant 0 is bit 4 of word1
    @(negedge clk);
    chk_sel = 17; chk_quad = 0; chk_write = 1; chk_priv = 0;
    bus_wr = 1; bus_priv = 1; bus_addr = 8'h28; bus_wdata = 32'h10;
    #1 check("R10", {31'b0, chk_allow}, 32'd1);
    @(negedge clk);
    bus_wr = 0; bus_priv = 0;
    #1 check("R10", {31'b0, chk_allow}, 32'd0);

    // R1 reset mid-run
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    rd("R1", 8'h44, 0); rd("R1", 8'h28, 0);
    acc("R1", 17, 0, 1, 0, 1);
    finish_run();
  end
endmodule